// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block holds the configuration words that steer a storage-interface PHY power sequencer, and it reports the sequencer's progress back to software. Seven 16-bit control words sit on a simple single-cycle register bus. A second 16-bit read-only word reports two status flags from the PHY. Each write carries its own bit-enable mask in the upper half of the data word. Software can therefore set or clear one control bit without first reading the register back.

The two status flags come from another clock domain. Each passes through a two-flop synchronizer before it can be read. Read data is registered: a read strobed at one rising edge presents its word on the read-data port from that edge until the next read strobe. The control word at byte offset 0x18 drives two dedicated outputs, analog power-up enable and DLL enable. All control words are also available on a flat output bus.

Top module: `mreg_ctrl_bank`

## Requirements
- R1: On a write to a control word, stored bit x (0..15) takes write-data bit x when write-data bit x+16 is 1.
- R2: On a write to a control word, stored bit x keeps its old value when write-data bit x+16 is 0.
- R3: Control word k (k = 0..6) sits at byte offset 4*k (0x00 to 0x18), and a write to one word leaves the other six unchanged. Flat output bits [16k+15:16k] carry word k.
- R4: A read of a control word returns its 16 stored bits in read-data bits [15:0] and zeros in bits [31:16].
- R5: After reset, every control bit is 0 and read data is 0, so power-up enable and DLL enable are both low.
- R6: Output phy_pwr_en follows bit 0 of the word at offset 0x18, and phy_dll_en follows bit 1 of that word.
- R7: A read at offset 0x20 returns the calibration-done flag in bit 6 and the DLL-ready flag in bit 5, with all other bits 0. A write to 0x20 changes no control word.
- R8: A write to an unmapped offset changes no control word. Unmapped offsets are 0x1C, 0x24 and above, and any offset whose two low bits are not 00. A read at an unmapped offset returns 0.
- R9: Status inputs pass through two register stages. A read strobed at the first or second rising edge after an input change still returns the old flag value. A read strobed at the third edge returns the new value.
- R10: Read data is registered at the edge where the read strobe is high. A read and a write to the same control word in that cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] values |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| phy_cal_done | input | 1 | Calibration complete flag from PHY (asynchronous) |
| phy_dll_ready | input | 1 | DLL locked flag from PHY (asynchronous) |
| phy_pwr_en | output | 1 | Analog power-up enable to PHY |
| phy_dll_en | output | 1 | DLL enable to PHY |
| ctrl_flat | output | 112 | All seven control words, word k at [16k+15:16k] |

## Verification
On every cycle, the assertions check three things. First, that a write changes exactly the enabled bits of the addressed word. Second, that non-addressed words, idle cycles and writes to the status or unmapped offsets leave the control state alone. Third, that read data never carries upper-half bits, and that the synchronizer output equals the input from two edges earlier. The bench scenarios are what show the address map itself: which offset reaches which word, which status bit carries which flag, the exact edge at which a changed flag becomes readable, and the old-value result of a read that coincides with a write.

// File: rtl/mreg_pkg.sv
package mreg_pkg;

    localparam int WORD_W      = 32;
    localparam int HALF_W      = WORD_W / 2;
    localparam int ADDR_W      = 8;
    localparam int IDX_W       = ADDR_W - 2;
    localparam int DEF_NCTRL   = 7;
    localparam int STAT_IDX    = 8;      // byte offset 0x20
    localparam int PWR_WORD    = 6;      // byte offset 0x18
    localparam int PWR_BIT     = 0;
    localparam int DLL_BIT     = 1;
    localparam int CAL_POS     = 6;
    localparam int DLLRDY_POS  = 5;
    localparam int STAT_W      = 2;      // [1]=cal done, [0]=dll ready

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } sel_e;

    typedef struct packed {
        sel_e             kind;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic [HALF_W-1:0] masked_merge(
        input logic [HALF_W-1:0] old_v,
        input logic [HALF_W-1:0] new_v,
        input logic [HALF_W-1:0] en
    );
        return (old_v & ~en) | (new_v & en);
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input logic [STAT_W-1:0] s);
        logic [WORD_W-1:0] w;
        w             = '0;
        w[CAL_POS]    = s[1];
        w[DLLRDY_POS] = s[0];
        return w;
    endfunction

endpackage

// File: rtl/mreg_decode.sv
module mreg_decode
    import mreg_pkg::*;
#(
    parameter int NUM_CTRL = DEF_NCTRL
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [IDX_W-1:0] CTRL_LIM = IDX_W'(NUM_CTRL);
    localparam logic [IDX_W-1:0] STAT_SEL = IDX_W'(STAT_IDX);

    logic             aligned;
    logic [IDX_W-1:0] widx;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = addr[ADDR_W-1:2];

    always_comb begin
        dec.idx  = widx;
        dec.kind = SEL_NONE;
        if (aligned && (widx < CTRL_LIM)) begin
            dec.kind = SEL_CTRL;
        end else if (aligned && (widx == STAT_SEL)) begin
            dec.kind = SEL_STAT;
        end
    end
endmodule

// File: rtl/mreg_cell.sv
module mreg_cell
    import mreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [HALF_W-1:0] val,
    input  logic [HALF_W-1:0] en,
    output logic [HALF_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= masked_merge(q, val, en);
        end
    end

    // R1: enabled bits take the written value
    assert_en_bits_load_R1: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & $past(en)) == ($past(val) & $past(en))));

    // R2: bits without enable keep their value
    assert_dis_bits_hold_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & ~$past(en)) == ($past(q) & ~$past(en))));

    // R3: no write strobe, no change
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/mreg_sync.sv
module mreg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg[0] <= '0;
        end else begin
            stg[0] <= din;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '0;
            end else begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

    if (STAGES == 2) begin : g_chk
        logic [1:0] since_rst;
        always_ff @(posedge clk) begin
            if (rst) begin
                since_rst <= '0;
            end else if (since_rst != 2'd2) begin
                since_rst <= since_rst + 2'd1;
            end
        end
        // R9: output equals input from two edges earlier
        assert_two_stage_delay_R9: assert property (@(posedge clk) disable iff (rst)
            (since_rst == 2'd2) |-> (dout == $past(din, 2)));
    end
endmodule

// File: rtl/mreg_ctrl_bank.sv
module mreg_ctrl_bank
    import mreg_pkg::*;
#(
    parameter int NUM_CTRL    = DEF_NCTRL,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic                       phy_cal_done,
    input  logic                       phy_dll_ready,
    output logic                       phy_pwr_en,
    output logic                       phy_dll_en,
    output logic [NUM_CTRL*HALF_W-1:0] ctrl_flat
);
    localparam int FLAT_W = NUM_CTRL * HALF_W;

    dec_t              dec;
    logic [HALF_W-1:0] ctrl_q [NUM_CTRL];
    logic [STAT_W-1:0] stat_raw;
    logic [STAT_W-1:0] stat_sync;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] rdata_q;

    mreg_decode #(.NUM_CTRL(NUM_CTRL)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
        logic we_k;
        assign we_k = bus_wr && (dec.kind == SEL_CTRL) && (dec.idx == IDX_W'(k));
        mreg_cell u_cell (
            .clk (clk),
            .rst (rst),
            .we  (we_k),
            .val (bus_wdata[HALF_W-1:0]),
            .en  (bus_wdata[WORD_W-1:HALF_W]),
            .q   (ctrl_q[k])
        );
        assign ctrl_flat[k*HALF_W +: HALF_W] = ctrl_q[k];
    end

    assign stat_raw = {phy_cal_done, phy_dll_ready};

    mreg_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (stat_raw),
        .dout (stat_sync)
    );

    always_comb begin
        rd_word = '0;
        case (dec.kind)
            SEL_CTRL: begin
                for (int k = 0; k < NUM_CTRL; k++) begin
                    if (dec.idx == IDX_W'(k)) begin
                        rd_word[HALF_W-1:0] = ctrl_q[k];
                    end
                end
            end
            SEL_STAT: rd_word = pack_status(stat_sync);
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_word;
        end
    end

    assign bus_rdata  = rdata_q;
    assign phy_pwr_en = ctrl_q[PWR_WORD][PWR_BIT];
    assign phy_dll_en = ctrl_q[PWR_WORD][DLL_BIT];

    // R5: reset clears control state and read data
    assert_reset_clear_R5: assert property (@(posedge clk)
        rst |=> ((ctrl_flat == '0) && (bus_rdata == '0)));

    // R4: upper half of read data is never set
    assert_rdata_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[WORD_W-1:HALF_W] == '0);

    // R7 / R8: writes outside the control window leave control state alone
    assert_nonctrl_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (dec.kind != SEL_CTRL)) |=> (ctrl_flat == $past(ctrl_flat)));

    // R10: read data only moves on a read strobe
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    logic unused_flat;
    assign unused_flat = ^ctrl_flat[FLAT_W-1:0] & 1'b0;
endmodule

// File: tb/sim_mreg_ctrl_bank.sv
`timescale 1ns/1ps
module sim_mreg_ctrl_bank;
    localparam int NCTRL = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic         phy_cal_done = 1'b0;
    logic         phy_dll_ready = 1'b0;
    logic         phy_pwr_en;
    logic         phy_dll_en;
    logic [111:0] ctrl_flat;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [NCTRL];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          done = 0;

    always #10 clk = ~clk;

    mreg_ctrl_bank u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .phy_cal_done(phy_cal_done), .phy_dll_ready(phy_dll_ready),
        .phy_pwr_en(phy_pwr_en), .phy_dll_en(phy_dll_en), .ctrl_flat(ctrl_flat)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver tasks: called at a falling edge, return at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a[1:0] == 2'b00 && a[7:2] < NCTRL)
            model[a[7:2]] = (model[a[7:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_ctrl(input int k, input string tag);
        rd(8'(4 * k), {16'h0, model[k]}, tag);
    endtask

    function automatic logic [111:0] flat_model();
        logic [111:0] f;
        for (int k = 0; k < NCTRL; k++) f[k*16 +: 16] = model[k];
        return f;
    endfunction

    // Monitor: compare each read result one cycle after its strobe edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard underflow: actual %0h expected none", bus_rdata);
                end else begin
                    check(tag_q.pop_front(), 128'(bus_rdata), 128'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NCTRL; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5: reset state
        check("R5 flat", 128'(ctrl_flat), 128'(0));
        check("R5 pwr/dll", 128'({phy_pwr_en, phy_dll_en}), 128'(0));
        check("R5 rdata", 128'(bus_rdata), 128'(0));
        for (int k = 0; k < NCTRL; k++) rd_ctrl(k, "R5 ctrl read");

        // R1/R6: set power bit only
        wr(8'h18, 32'h0001_0001);
        check("R6 pwr on", 128'({phy_pwr_en, phy_dll_en}), 128'(2'b10));
        // R1/R2: set dll bit, try to clear power bit without its enable
        wr(8'h18, 32'h0002_0002);
        check("R2 pwr held, R6 dll on", 128'({phy_pwr_en, phy_dll_en}), 128'(2'b11));
        // R2: no enables at all
        wr(8'h18, 32'h0000_0000);
        check("R2 no-enable write", 128'({phy_pwr_en, phy_dll_en}), 128'(2'b11));
        // R1: clear power bit only
        wr(8'h18, 32'h0001_0000);
        check("R1 clear pwr", 128'({phy_pwr_en, phy_dll_en}), 128'(2'b01));
        rd_ctrl(6, "R4 ctrl6 read");

        // R3: each word its own pattern, checked isolated
        for (int k = 0; k < NCTRL - 1; k++) begin
            wr(8'(4 * k), {16'hFFFF, 16'hA5C0 ^ 16'(k * 16'h1111)});
            check("R3 flat after write", 128'(ctrl_flat), 128'(flat_model()));
        end
        // R1/R2: partial enables on word 2
        wr(8'h08, 32'h0F0F_1234);
        check("R1 R2 partial mask", 128'(ctrl_flat), 128'(flat_model()));
        for (int k = 0; k < NCTRL; k++) rd_ctrl(k, "R4 R3 readback");

        // R7/R8: writes outside control window
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_0000);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h06, 32'hFFFF_0000);
        check("R8 R7 ignored writes", 128'(ctrl_flat), 128'(flat_model()));
        rd(8'h1C, 32'h0, "R8 read 0x1C");
        rd(8'h24, 32'h0, "R8 read 0x24");
        rd(8'h05, 32'h0, "R8 read unaligned");
        rd(8'hFC, 32'h0, "R8 read 0xFC");
        rd(8'h20, 32'h0, "R7 status idle");

        // R9: raise cal done, reads at edges 1,2 old, 3 new
        phy_cal_done = 1'b1;
        rd(8'h20, 32'h0, "R9 edge1 old");
        rd(8'h20, 32'h0, "R9 edge2 old");
        rd(8'h20, 32'h0000_0040, "R9 R7 edge3 cal bit6");
        phy_dll_ready = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h20, 32'h0000_0060, "R7 both flags");
        phy_cal_done = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h20, 32'h0000_0020, "R7 dll bit5 only");

        // R10: read and write to same word in one cycle
        bus_addr = 8'h0C; bus_wdata = 32'hFFFF_0BAD; bus_wr = 1'b1; bus_rd = 1'b1;
        exp_q.push_back({16'h0, model[3]});
        tag_q.push_back("R10 read-during-write old value");
        model[3] = 16'h0BAD;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        rd_ctrl(3, "R10 new value next read");
        check("R10 flat", 128'(ctrl_flat), 128'(flat_model()));

        // R5: reset again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NCTRL; k++) model[k] = '0;
        check("R5 flat after reset", 128'(ctrl_flat), 128'(0));
        check("R5 rdata after reset", 128'(bus_rdata), 128'(0));

        repeat (2) @(negedge clk);
        check("scoreboard drained", 128'(exp_q.size()), 128'(0));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule